// File: doc/BRIEF.md
# SPI Slave with Receive Descriptor Ring

This block answers an external SPI master. It has a local transmit buffer and a ring of receive buffers. Software fills the transmit buffer, sets its length and pulses a start input. The slave then loads the first outgoing byte onto MISO and waits for the active-low select. While select is low, the master's clock shifts one byte out on MISO and one byte in from MOSI at a time. The bus uses mode 0 and sends the most significant bit first.

Each receive buffer holds up to 16 bytes. Software hands a buffer to the block by pulsing one bit of a give vector. The block fills the current buffer. When it is full, the block closes it and moves on to the next buffer, going from the last back to the first. Reception goes on until no empty buffer is left or select is released. Releasing select also closes a partly filled buffer. Three sticky event flags (transmit done, buffer closed, overrun) drive a maskable interrupt.

The clock, data and select inputs pass through two-flop synchronizers. Their edges are found in the system clock domain, so the serial clock must stay at or below half the system clock. The synchronizer and edge detection add a few cycles of delay, so each clock phase must last longer than that.

Top module: `spis_ring_slave`

## Requirements
- R1: After reset, irq_o and ev_o are 0, every receive buffer is marked not empty with count 0, and miso_o is 1.
- R2: Edges on sck_i and values on mosi_i cause no reception and no change in any buffer while sel_ni is high, and also before the first start_i pulse. Before start_i, miso_o stays 1.
- R3: While selected and started, MOSI is sampled on each rising sck_i and MISO moves to the next bit on each falling sck_i, most significant bit first. The first bit of a byte is on miso_o before that byte's first rising edge.
- R4: start_i captures tx_len_i (0 to 16) and restarts the transmit index. The k-th byte exchanged after start_i sends transmit buffer entry k while k < length, and 8'hFF after that.
- R5: A give pulse on rx_give_i bit d marks buffer d empty with count 0. A received byte goes into the current empty buffer at the offset equal to its count, and the count then goes up by one.
- R6: When the 16th byte lands in a buffer, that buffer is marked not empty with count 16, ev_o bit 1 is set, and reception moves to the next buffer.
- R7: After the last buffer (index 3), reception goes back to buffer 0.
- R8: A byte that completes while the current buffer is not empty is dropped, and ev_o bit 2 (overrun) is set.
- R9: When sel_ni rises, any partly shifted bits are discarded. If the current buffer holds at least one byte, it is closed with its count, ev_o bit 1 is set, and reception moves to the next buffer.
- R10: ev_o bit 0 is set when the byte that uses the last transmit buffer entry completes.
- R11: ev_o bits stay set until cleared by writing ones on ev_clr_i. irq_o is 1 exactly when some ev_o bit and the matching irq_en_i bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms the slave, captures the transmit length and restarts the index |
| tx_len_i | input | 5 | Number of valid transmit bytes |
| tx_we_i | input | 1 | Transmit buffer write enable |
| tx_waddr_i | input | 4 | Transmit buffer write address |
| tx_wdata_i | input | 8 | Transmit buffer write data |
| rx_give_i | input | 4 | One pulse bit per receive buffer, marks it empty |
| rx_rd_desc_i | input | 2 | Receive buffer selected for read |
| rx_rd_addr_i | input | 4 | Byte offset to read |
| rx_rd_data_o | output | 8 | Received byte at that buffer and offset |
| rx_empty_o | output | 4 | Empty flag of each receive buffer |
| rx_count_o | output | 20 | Byte count of each buffer, 5 bits each, buffer 0 in the low bits |
| ev_clr_i | input | 3 | Write-one-to-clear for the event flags |
| irq_en_i | input | 3 | Interrupt enable for each event flag |
| ev_o | output | 3 | Sticky events: bit 0 transmit done, bit 1 buffer closed, bit 2 overrun |
| irq_o | output | 1 | Maskable interrupt |
| sck_i | input | 1 | Serial clock from the master, idle low |
| mosi_i | input | 1 | Serial data from the master |
| sel_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |

## Verification
The assertions assume that each half period of sck_i lasts many system clocks, that mosi_i is stable around every rising sck_i, and that sel_ni changes only while sck_i is low. They also assume that give pulses and start_i arrive only while select is released. The stimulus meets these conditions. Every sck_i phase lasts eight system clocks. Select is asserted and released with the serial clock low, with idle gaps before and after. Buffers are handed over, and start_i pulsed, only between transfers. Random byte counts, transmit lengths, give masks and enables change around this fixed timing. Directed cases cover a partial final byte, a buffer that fills, wrap-around of the ring, and an overrun.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned EV_N   = 3;
  localparam int unsigned EV_TXD = 0;
  localparam int unsigned EV_RXC = 1;
  localparam int unsigned EV_OVR = 2;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spis_shift.sv
module spis_shift import spis_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              sel_i,
  input  logic              arm_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sel_end_o,
  output logic              miso_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic              sck_q, sel_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] in_q, out_q;
  logic              active, rise, fall;

  assign active = sel_i & arm_i;
  assign rise   = active & sck_i & ~sck_q;
  assign fall   = active & ~sck_i & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
      bit_q <= '0;
      in_q  <= '0;
      out_q <= '1;
    end else begin
      sck_q <= sck_i;
      sel_q <= sel_i;
      if (!active) begin
        bit_q <= '0;
        out_q <= load_i;
      end else begin
        if (rise) begin
          in_q  <= {in_q[BYTE_W-2:0], mosi_i};
          bit_q <= bit_q + BIT_W'(1);
        end
        // bit counter back at zero on a fall: next byte goes out
        if (fall) out_q <= (bit_q == '0) ? load_i : {out_q[BYTE_W-2:0], 1'b1};
      end
    end
  end

  assign byte_done_o = rise && (bit_q == BIT_W'(BYTE_W-1));
  assign byte_o      = {in_q[BYTE_W-2:0], mosi_i};
  assign sel_end_o   = sel_q & ~sel_i;
  assign miso_o      = out_q[BYTE_W-1];
endmodule

// File: rtl/spis_rx_ring.sv
module spis_rx_ring import spis_pkg::*; #(
  parameter  int unsigned BUF_DEPTH = 16,
  parameter  int unsigned RING_N    = 4,
  localparam int unsigned ADDR_W    = $clog2(BUF_DEPTH),
  localparam int unsigned CNT_W     = $clog2(BUF_DEPTH+1),
  localparam int unsigned PTR_W     = (RING_N > 1) ? $clog2(RING_N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_done_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    sel_end_i,
  input  logic [RING_N-1:0]       give_i,
  input  logic [PTR_W-1:0]        rd_desc_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [BYTE_W-1:0]       rd_data_o,
  output logic [RING_N-1:0]       empty_o,
  output logic [RING_N*CNT_W-1:0] count_o,
  output logic [PTR_W-1:0]        ptr_o,
  output logic                    close_o,
  output logic                    ovr_o
);
  localparam int unsigned MEM_N  = RING_N * BUF_DEPTH;
  localparam int unsigned MEM_AW = $clog2(MEM_N);

  logic [BYTE_W-1:0] mem_q [MEM_N];
  logic [RING_N-1:0] empty_q;
  logic [CNT_W-1:0]  cnt_q [RING_N];
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic              cur_empty, last_slot, store, close_part;
  logic [CNT_W-1:0]  cur_cnt;
  logic [MEM_AW-1:0] wr_addr, rd_addr;

  assign cur_empty  = empty_q[ptr_q];
  assign cur_cnt    = cnt_q[ptr_q];
  assign last_slot  = cur_cnt == CNT_W'(BUF_DEPTH-1);
  assign ptr_nxt    = (ptr_q == PTR_W'(RING_N-1)) ? PTR_W'(0) : ptr_q + PTR_W'(1);
  assign store      = byte_done_i && cur_empty;
  assign close_part = !byte_done_i && sel_end_i && cur_empty && (cur_cnt != '0);
  assign wr_addr    = MEM_AW'(ptr_q) * MEM_AW'(BUF_DEPTH) + MEM_AW'(cur_cnt);
  assign rd_addr    = MEM_AW'(rd_desc_i) * MEM_AW'(BUF_DEPTH) + MEM_AW'(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < RING_N; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < RING_N; i++) begin
        if (give_i[i]) begin
          empty_q[i] <= 1'b1;
          cnt_q[i]   <= '0;
        end
      end
      if (store) begin
        cnt_q[ptr_q] <= cur_cnt + CNT_W'(1);
        if (last_slot) begin
          empty_q[ptr_q] <= 1'b0;
          ptr_q          <= ptr_nxt;
        end
      end else if (close_part) begin
        empty_q[ptr_q] <= 1'b0;
        ptr_q          <= ptr_nxt;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (store) mem_q[wr_addr] <= byte_i;
  end

  for (genvar g = 0; g < RING_N; g++) begin : g_cnt
    assign count_o[g*CNT_W +: CNT_W] = cnt_q[g];
  end

  assign rd_data_o = mem_q[rd_addr];
  assign empty_o   = empty_q;
  assign ptr_o     = ptr_q;
  assign close_o   = (store && last_slot) || close_part;
  assign ovr_o     = byte_done_i && !cur_empty;
endmodule

// File: rtl/spis_ring_slave.sv
module spis_ring_slave import spis_pkg::*; #(
  parameter  int unsigned BUF_DEPTH = 16,
  parameter  int unsigned RING_N    = 4,
  localparam int unsigned ADDR_W    = $clog2(BUF_DEPTH),
  localparam int unsigned CNT_W     = $clog2(BUF_DEPTH+1),
  localparam int unsigned PTR_W     = (RING_N > 1) ? $clog2(RING_N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        tx_len_i,
  input  logic                    tx_we_i,
  input  logic [ADDR_W-1:0]       tx_waddr_i,
  input  logic [BYTE_W-1:0]       tx_wdata_i,
  input  logic [RING_N-1:0]       rx_give_i,
  input  logic [PTR_W-1:0]        rx_rd_desc_i,
  input  logic [ADDR_W-1:0]       rx_rd_addr_i,
  output logic [BYTE_W-1:0]       rx_rd_data_o,
  output logic [RING_N-1:0]       rx_empty_o,
  output logic [RING_N*CNT_W-1:0] rx_count_o,
  input  logic [EV_N-1:0]         ev_clr_i,
  input  logic [EV_N-1:0]         irq_en_i,
  output logic [EV_N-1:0]         ev_o,
  output logic                    irq_o,
  input  logic                    sck_i,
  input  logic                    mosi_i,
  input  logic                    sel_ni,
  output logic                    miso_o
);
  logic [2:0]        sync_q;
  logic              sck_s, mosi_s, sel_act;
  logic [BYTE_W-1:0] tx_mem [BUF_DEPTH];
  logic              armed_q, tx_left;
  logic [CNT_W-1:0]  tx_len_q, tx_idx_q;
  logic [BYTE_W-1:0] load_byte, rx_byte;
  logic              byte_done, sel_end, rx_close, rx_ovr, tx_done;
  logic [PTR_W-1:0]  rx_ptr;
  logic [EV_N-1:0]   ev_q, ev_set;

  spis_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sel_ni, mosi_i, sck_i}),
    .q_o (sync_q)
  );
  assign sel_act = ~sync_q[2];
  assign mosi_s  = sync_q[1];
  assign sck_s   = sync_q[0];

  always_ff @(posedge clk_i) begin
    if (tx_we_i) tx_mem[tx_waddr_i] <= tx_wdata_i;
  end

  assign tx_left   = tx_idx_q < tx_len_q;
  assign load_byte = (armed_q && tx_left) ? tx_mem[tx_idx_q[ADDR_W-1:0]] : '1;
  assign tx_done   = byte_done && tx_left && ((tx_idx_q + CNT_W'(1)) == tx_len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      tx_len_q <= '0;
      tx_idx_q <= '0;
    end else if (start_i) begin
      armed_q  <= 1'b1;
      tx_idx_q <= '0;
      tx_len_q <= (tx_len_i > CNT_W'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : tx_len_i;
    end else if (byte_done && tx_left) begin
      tx_idx_q <= tx_idx_q + CNT_W'(1);
    end
  end

  spis_shift u_shift (
    .clk_i, .rst_ni,
    .sck_i       (sck_s),
    .mosi_i      (mosi_s),
    .sel_i       (sel_act),
    .arm_i       (armed_q),
    .load_i      (load_byte),
    .byte_done_o (byte_done),
    .byte_o      (rx_byte),
    .sel_end_o   (sel_end),
    .miso_o      (miso_o)
  );

  spis_rx_ring #(.BUF_DEPTH(BUF_DEPTH), .RING_N(RING_N)) u_ring (
    .clk_i, .rst_ni,
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .sel_end_i   (sel_end),
    .give_i      (rx_give_i),
    .rd_desc_i   (rx_rd_desc_i),
    .rd_addr_i   (rx_rd_addr_i),
    .rd_data_o   (rx_rd_data_o),
    .empty_o     (rx_empty_o),
    .count_o     (rx_count_o),
    .ptr_o       (rx_ptr),
    .close_o     (rx_close),
    .ovr_o       (rx_ovr)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXD] = tx_done;
    ev_set[EV_RXC] = rx_close;
    ev_set[EV_OVR] = rx_ovr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~ev_clr_i) | ev_set;
  end

  assign ev_o  = ev_q;
  assign irq_o = |(ev_q & irq_en_i);
endmodule

// File: rtl/spis_checks.sv
module spis_checks import spis_pkg::*; #(
  parameter  int unsigned BUF_DEPTH = 16,
  parameter  int unsigned RING_N    = 4,
  localparam int unsigned CNT_W     = $clog2(BUF_DEPTH+1),
  localparam int unsigned PTR_W     = (RING_N > 1) ? $clog2(RING_N) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sel_act,
  input logic                    byte_done,
  input logic [PTR_W-1:0]        rx_ptr,
  input logic [RING_N-1:0]       rx_empty,
  input logic [RING_N*CNT_W-1:0] rx_count,
  input logic [EV_N-1:0]         ev_q,
  input logic                    miso_o,
  input logic [CNT_W-1:0]        tx_idx_q,
  input logic [CNT_W-1:0]        tx_len_q
);
  logic [CNT_W-1:0] cur_cnt;
  assign cur_cnt = rx_count[rx_ptr*CNT_W +: CNT_W];

  assert_quiet_unselected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_act |-> !byte_done);

  assert_fill_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_act && (tx_idx_q >= tx_len_q)) |-> miso_o);

  assert_close_on_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && rx_empty[rx_ptr] && (cur_cnt == CNT_W'(BUF_DEPTH-1))
    |=> !rx_empty[$past(rx_ptr)]);

  assert_ring_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ptr != $past(rx_ptr)) |->
    rx_ptr == (($past(rx_ptr) == PTR_W'(RING_N-1)) ? PTR_W'(0) : $past(rx_ptr) + PTR_W'(1)));

  assert_overrun_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !rx_empty[rx_ptr] |=> ev_q[EV_OVR]);
endmodule

bind spis_ring_slave spis_checks #(.BUF_DEPTH(BUF_DEPTH), .RING_N(RING_N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_act   (sel_act),
  .byte_done (byte_done),
  .rx_ptr    (rx_ptr),
  .rx_empty  (rx_empty_o),
  .rx_count  (rx_count_o),
  .ev_q      (ev_q),
  .miso_o    (miso_o),
  .tx_idx_q  (tx_idx_q),
  .tx_len_q  (tx_len_q)
);

// File: tb/sim_spis_ring_slave.sv
`timescale 1ns/1ps
module sim_spis_ring_slave;
  localparam int DEPTH = 16;
  localparam int NR    = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  tx_len_i = '0;
  logic        tx_we_i = 1'b0;
  logic [3:0]  tx_waddr_i = '0;
  logic [7:0]  tx_wdata_i = '0;
  logic [3:0]  rx_give_i = '0;
  logic [1:0]  rx_rd_desc_i = '0;
  logic [3:0]  rx_rd_addr_i = '0;
  logic [7:0]  rx_rd_data_o;
  logic [3:0]  rx_empty_o;
  logic [19:0] rx_count_o;
  logic [2:0]  ev_clr_i = '0;
  logic [2:0]  irq_en_i = '0;
  logic [2:0]  ev_o;
  logic        irq_o;
  logic        sck_i = 1'b0;
  logic        mosi_i = 1'b0;
  logic        sel_ni = 1'b1;
  logic        miso_o;

  always #2 clk = ~clk;

  spis_ring_slave u0 (
    .clk_i(clk), .rst_ni, .start_i, .tx_len_i, .tx_we_i, .tx_waddr_i, .tx_wdata_i,
    .rx_give_i, .rx_rd_desc_i, .rx_rd_addr_i, .rx_rd_data_o, .rx_empty_o, .rx_count_o,
    .ev_clr_i, .irq_en_i, .ev_o, .irq_o, .sck_i, .mosi_i, .sel_ni, .miso_o
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit       m_empty [NR];
  int       m_cnt   [NR];
  bit [7:0] m_mem   [NR][DEPTH];
  int       m_ptr;
  bit [2:0] m_ev;
  bit [7:0] m_tx    [DEPTH];
  int       m_txlen, m_txi;
  bit       m_armed;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] m, input int nbits, output logic [7:0] got);
    got = '1;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi_i = m[b];
      wait_n(8);
      got[b] = miso_o;
      sck_i = 1'b1;
      wait_n(8);
      sck_i = 1'b0;
    end
  endtask

  function automatic int next_ptr(input int p);
    return (p == NR-1) ? 0 : p + 1;
  endfunction

  task automatic model_rx(input bit [7:0] b);
    if (m_empty[m_ptr]) begin
      m_mem[m_ptr][m_cnt[m_ptr]] = b;
      m_cnt[m_ptr]++;
      if (m_cnt[m_ptr] == DEPTH) begin
        m_empty[m_ptr] = 1'b0;
        m_ev[1] = 1'b1;
        m_ptr = next_ptr(m_ptr);
      end
    end else begin
      m_ev[2] = 1'b1;
    end
  endtask

  function automatic bit [7:0] model_tx();
    bit [7:0] r;
    r = (m_armed && m_txi < m_txlen) ? m_tx[m_txi] : 8'hFF;
    if (m_armed && m_txi < m_txlen) begin
      m_txi++;
      if (m_txi == m_txlen) m_ev[0] = 1'b1;
    end
    return r;
  endfunction

  task automatic check_state(input string tag);
    for (int d = 0; d < NR; d++) begin
      chk({tag, " R5 R6 R9 empty flag"}, int'(rx_empty_o[d]), int'(m_empty[d]));
      chk({tag, " R5 R6 R9 count"}, int'(rx_count_o[d*5 +: 5]), m_cnt[d]);
      for (int j = 0; j < m_cnt[d]; j++) begin
        rx_rd_desc_i = 2'(d);
        rx_rd_addr_i = 4'(j);
        #1;
        chk({tag, " R5 stored byte"}, int'(rx_rd_data_o), int'(m_mem[d][j]));
      end
    end
    chk({tag, " R11 events"}, int'(ev_o), int'(m_ev));
    chk({tag, " R11 irq"}, int'(irq_o), int'(|(m_ev & irq_en_i)));
  endtask

  task automatic episode(input string tag, input int nb, input int part,
                         input logic [3:0] give, input int txlen, input logic [2:0] en,
                         input bit do_start);
    logic [7:0] got, m;
    bit [7:0] e;
    @(negedge clk);
    ev_clr_i = 3'b111;
    rx_give_i = give;
    irq_en_i = en;
    m_ev = '0;
    for (int d = 0; d < NR; d++) if (give[d]) begin m_empty[d] = 1'b1; m_cnt[d] = 0; end
    @(negedge clk);
    ev_clr_i = '0;
    rx_give_i = '0;
    if (do_start) begin
      for (int i = 0; i < txlen; i++) begin
        m_tx[i] = 8'($urandom);
        tx_we_i = 1'b1; tx_waddr_i = 4'(i); tx_wdata_i = m_tx[i];
        @(negedge clk);
      end
      tx_we_i = 1'b0;
      tx_len_i = 5'(txlen);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      m_armed = 1'b1; m_txlen = txlen; m_txi = 0;
    end
    wait_n(4);
    sel_ni = 1'b0;
    wait_n(8);
    for (int k = 0; k < nb; k++) begin
      m = 8'($urandom);
      xfer(m, 8, got);
      e = model_tx();
      chk({tag, " R3 R4 miso byte"}, int'(got), int'(e));
      if (m_armed) model_rx(m);
    end
    if (part > 0) xfer(8'($urandom), part, got);
    wait_n(8);
    sel_ni = 1'b1;
    wait_n(10);
    if (m_empty[m_ptr] && m_cnt[m_ptr] > 0) begin
      m_empty[m_ptr] = 1'b0;
      m_ev[1] = 1'b1;
      m_ptr = next_ptr(m_ptr);
    end
    check_state(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd2024));
    for (int d = 0; d < NR; d++) begin m_empty[d] = 1'b0; m_cnt[d] = 0; end
    m_ptr = 0; m_ev = '0; m_txlen = 0; m_txi = 0; m_armed = 1'b0;
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(5);
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 events", int'(ev_o), 0);
    chk("R1 empty flags", int'(rx_empty_o), 0);
    chk("R1 counts", int'(rx_count_o), 0);
    chk("R1 miso idle", int'(miso_o), 1);

    // R2: selected but never started: nothing received, miso all ones
    episode("R2 unarmed", 2, 0, 4'hF, 0, 3'b000, 1'b0);

    // R2: started, clocks while unselected are ignored
    tx_len_i = 0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    m_armed = 1'b1; m_txlen = 0; m_txi = 0;
    for (int i = 0; i < 16; i++) begin
      mosi_i = 1'($urandom); sck_i = 1'b1; wait_n(8); sck_i = 1'b0; wait_n(8);
    end
    chk("R2 counts while unselected", int'(rx_count_o), 0);
    chk("R2 events while unselected", int'(ev_o), 0);
    chk("R2 empty while unselected", int'(rx_empty_o), 4'hF);

    // R4 R10 R9: 3 tx bytes, 5 exchanged, buffer 0 closed with count 5
    episode("R4 R10 short", 5, 0, 4'h0, 3, 3'b011, 1'b1);
    chk("R10 tx done flag", int'(ev_o[0]), 1);
    // R9: partial byte discarded, buffer 1 closed with 2
    episode("R9 partial", 2, 3, 4'h0, 4, 3'b010, 1'b1);
    chk("R9 partial count", int'(rx_count_o[5 +: 5]), 2);
    // R6 R7: fill buffer 2, 4 bytes into 3, wrap to 0
    episode("R6 R7 fill wrap", 20, 0, 4'h0, 16, 3'b001, 1'b1);
    chk("R6 full count", int'(rx_count_o[10 +: 5]), 16);
    // R8: buffer 0 still full -> overrun
    episode("R8 overrun", 2, 0, 4'h0, 1, 3'b100, 1'b1);
    chk("R8 overrun flag", int'(ev_o[2]), 1);
    chk("R11 irq enabled", int'(irq_o), 1);
    @(negedge clk); irq_en_i = 3'b000; #1;
    chk("R11 irq masked", int'(irq_o), 0);
    @(negedge clk); ev_clr_i = 3'b100; @(negedge clk); ev_clr_i = '0; #1;
    chk("R11 clear overrun", int'(ev_o[2]), 0);
    m_ev[2] = 1'b0;
    chk("R11 others sticky", int'(ev_o), int'(m_ev));

    // random episodes
    for (int ep = 0; ep < 24; ep++) begin
      logic [3:0] gv;
      gv = '0;
      for (int d = 0; d < NR; d++) if (!m_empty[d] && ($urandom % 4 != 0)) gv[d] = 1'b1;
      episode("R5 random", 1 + int'($urandom % 18), int'($urandom % 3) * 3, gv,
              int'($urandom % 17), 3'($urandom), 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule